// File: doc/BRIEF.md
# Digit Pattern Occurrence Counter

This block watches a stream of decimal digits, one per accepted transfer, and counts how many times the three-digit run 3, 5, 8 appears. The count is kept modulo 5, so it runs 0, 1, 2, 3, 4 and then back to 0. The count is the only result, and it comes straight from a register.

Inside there are two state machines, one feeding the other. A small tracker remembers how much of the run has been seen so far. It has three states: idle, "last digit was 3", and "last two digits were 3 then 5". When the tracker is in its last state and an 8 is accepted, it sends a one-cycle pulse to a modulo-5 occurrence counter. Codes 10 to 15 on the digit input are treated like any digit that is not part of the run.

The input is a valid/ready stream. The block never applies back-pressure: ready is high in every cycle, so a digit is accepted in each cycle where valid is high. When valid is low, no digit is consumed and both state machines hold their state. A synchronous, active-high reset clears both state machines.

Top module: `digit_seq_counter`

## Requirements
- R1: One clock edge with rst high sets occ_count to 0 and returns the tracker to idle. After reset, the digits 5, 8 do not count, but the digits 3, 5, 8 do.
- R2: occ_count always holds a value from 0 to 4. It changes only on the clock edge that accepts the final 8 of a run, so the new value is visible in the cycle after that edge.
- R3: Accepting 3, 5, 8 on consecutive accepted transfers increases occ_count by exactly one, modulo 5.
- R4: An accepted 3 arms the tracker from any state. For example, 3, 3, 5, 8 counts once, and 3, 5, 3, 5, 8 counts once.
- R5: A run that is broken by any other digit does not count. Examples: 3, 5, 7, 8; 3, 4, 5, 8; 3, 8; 5, 8.
- R6: When occ_count is 4, the next completed run returns it to 0.
- R7: A cycle with in_valid low changes neither the count nor the tracker. Idle cycles placed between the digits of a run do not break the run.
- R8: Input codes 10 to 15 act as non-run digits. They break a partial run and never arm the tracker.
- R9: in_ready is 1 in every cycle, including during reset, so the block never stalls the source.
- R10: occ_count either holds its value or advances by one step modulo 5. It never takes any other step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A digit is offered on in_digit |
| in_ready | output | 1 | Block accepts a digit; always 1 |
| in_digit | input | 4 | Digit code, 0 to 9 meaningful, 10 to 15 treated as other |
| occ_count | output | 3 | Number of runs seen, modulo 5 |

## Verification
The only result, occ_count, is due exactly one clock edge after the accepting edge of the final 8, because the count register is the only register between a digit and the output. The bench drives every digit on the falling edge and updates its reference model on the rising edge that accepts the digit. It then compares occ_count on the next falling edge, so every comparison falls in the first cycle where the new value is visible. in_ready is checked combinationally in the same half cycle in which it is driven, including while reset is held.

// File: rtl/digit_seq_pkg.sv
package digit_seq_pkg;

  // Width of one digit code on the stream
  localparam int DIGIT_W = 4;

  // Number of symbols in the watched run
  localparam int RUN_LEN = 3;

  // Progress of the tracker through the run
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_GOT1 = 2'd1,
    TRK_GOT2 = 2'd2
  } trk_state_t;

  // Symbol of the run at a given position (0 = first)
  function automatic logic [DIGIT_W-1:0] run_symbol(
    input int                 pos,
    input logic [DIGIT_W-1:0] s0,
    input logic [DIGIT_W-1:0] s1,
    input logic [DIGIT_W-1:0] s2
  );
    case (pos)
      0:       run_symbol = s0;
      1:       run_symbol = s1;
      default: run_symbol = s2;
    endcase
  endfunction

endpackage

// File: rtl/dsc_digit_match.sv
module dsc_digit_match #(
  parameter int              W     = 4,
  parameter logic [W-1:0]    MATCH = '0
) (
  input  logic [W-1:0] digit,
  output logic         hit
);
  // Full-width compare, so codes above 9 never alias a run symbol
  assign hit = (digit == MATCH);
endmodule

// File: rtl/dsc_tracker.sv
module dsc_tracker
  import digit_seq_pkg::*;
#(
  parameter int N_SYM = RUN_LEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [N_SYM-1:0] hit,
  output trk_state_t       state,
  output logic             complete
);
  trk_state_t state_nx;

  // The first symbol arms from any state. The second symbol advances only
  // when the tracker is armed. Anything else falls back to idle.
  always_comb begin
    state_nx = state;
    if (accept) begin
      if (hit[0])
        state_nx = TRK_GOT1;
      else if (state == TRK_GOT1 && hit[1])
        state_nx = TRK_GOT2;
      else
        state_nx = TRK_IDLE;
    end
  end

  // The run closes when the final symbol arrives in the last tracker state
  assign complete = accept && (state == TRK_GOT2) && hit[N_SYM-1];

  always_ff @(posedge clk) begin
    if (rst) state <= TRK_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/dsc_modcount.sv
module dsc_modcount #(
  parameter int MODULUS = 5,
  parameter int CW      = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = CW'(MODULUS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (step)
      count <= (count == TOP) ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/digit_seq_counter.sv
module digit_seq_counter
  import digit_seq_pkg::*;
#(
  parameter logic [DIGIT_W-1:0] SYM_FIRST  = 4'd3,
  parameter logic [DIGIT_W-1:0] SYM_SECOND = 4'd5,
  parameter logic [DIGIT_W-1:0] SYM_THIRD  = 4'd8,
  parameter int                 MODULUS    = 5,
  parameter int                 CW         = $clog2(MODULUS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DIGIT_W-1:0] in_digit,
  output logic [CW-1:0]      occ_count
);
  logic [RUN_LEN-1:0] sym_hit;
  logic               accept;
  logic               run_done;
  trk_state_t         trk_state;

  // No back-pressure: every offered digit is taken
  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  // One comparator per run position
  for (genvar i = 0; i < RUN_LEN; i++) begin : g_match
    dsc_digit_match #(
      .W     (DIGIT_W),
      .MATCH (run_symbol(i, SYM_FIRST, SYM_SECOND, SYM_THIRD))
    ) u_match (
      .digit (in_digit),
      .hit   (sym_hit[i])
    );
  end

  dsc_tracker #(.N_SYM(RUN_LEN)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .hit      (sym_hit),
    .state    (trk_state),
    .complete (run_done)
  );

  dsc_modcount #(.MODULUS(MODULUS), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (run_done),
    .count (occ_count)
  );
endmodule

// File: rtl/digit_seq_counter_chk.sv
module digit_seq_counter_chk #(
  parameter int DW      = 4,
  parameter int CW      = 3,
  parameter int MODULUS = 5,
  parameter logic [DW-1:0] SYM_THIRD = 4'd8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_digit,
  input logic [CW-1:0] occ_count
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after a reset edge shows a zero count
  p_reset_clear_r1: assert property (@(posedge clk)
    rst_q |-> occ_count == '0);

  // R2: the count stays inside the modulus
  p_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    occ_count < CW'(MODULUS));

  // R7: an idle cycle leaves the count alone
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(occ_count));

  // R5: only the final run symbol can move the count
  p_only_final_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_digit != SYM_THIRD) |=> $stable(occ_count));

  // R10: the count holds or advances by one step with wrap
  p_single_step_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(occ_count) |->
      occ_count == (($past(occ_count) == CW'(MODULUS - 1)) ? '0
                                                           : $past(occ_count) + 1'b1));

  // R9: the source is never stalled
  p_never_stall_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> in_ready);
endmodule

bind digit_seq_counter digit_seq_counter_chk #(
  .DW        (digit_seq_pkg::DIGIT_W),
  .CW        (CW),
  .MODULUS   (MODULUS),
  .SYM_THIRD (SYM_THIRD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_digit  (in_digit),
  .occ_count (occ_count)
);

// File: tb/digit_seq_counter_test.sv
module digit_seq_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] in_digit = 4'd0;
  logic       in_ready;
  logic [2:0] occ_count;

  int checks = 0;
  int errors = 0;

  // Reference model: 0 idle, 1 saw 3, 2 saw 3,5
  int m_trk = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  digit_seq_counter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_digit(in_digit), .occ_count(occ_count)
  );

  function automatic int trk_next(input int s, input int d);
    if (d == 3) return 1;
    if (s == 1 && d == 5) return 2;
    return 0;
  endfunction

  function automatic int cnt_next(input int s, input int c, input int d);
    if (s == 2 && d == 8) return (c + 1) % 5;
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, model at the rising edge, check at the next fall
  task automatic step(input bit v, input int d, input string req);
    in_valid = v;
    in_digit = 4'(d);
    check("R9", int'(in_ready), 1);
    @(posedge clk);
    if (v) begin
      int nc;
      nc = cnt_next(m_trk, m_cnt, d);
      m_trk = trk_next(m_trk, d);
      m_cnt = nc;
    end
    @(negedge clk);
    check(req, int'(occ_count), m_cnt);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R9", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;
    m_trk = 0;
    m_cnt = 0;
    check("R1", int'(occ_count), 0);
  endtask

  task automatic seq3(input int a, input int b, input int c, input string req);
    step(1, a, req);
    step(1, b, req);
    step(1, c, req);
  endtask

  initial begin
    int seed;
    seed = 13579;
    void'($urandom(seed));
    @(negedge clk);
    do_reset();

    // R1: a 5,8 right after reset does not count; 3,5,8 does
    step(1, 5, "R1"); step(1, 8, "R1");
    check("R1", int'(occ_count), 0);
    seq3(3, 5, 8, "R3");
    check("R3", int'(occ_count), 1);

    // R4: re-arm on 3 from armed state and from the second state
    step(1, 3, "R4"); seq3(3, 5, 8, "R4");
    check("R4", int'(occ_count), 2);
    step(1, 3, "R4"); step(1, 5, "R4"); seq3(3, 5, 8, "R4");
    check("R4", int'(occ_count), 3);

    // R5: broken runs
    step(1, 3, "R5"); seq3(5, 7, 8, "R5");
    seq3(3, 4, 5, "R5"); step(1, 8, "R5");
    step(1, 3, "R5"); step(1, 8, "R5");
    check("R5", int'(occ_count), 3);

    // R8: codes above 9 break a partial run and never arm
    step(1, 3, "R8"); step(1, 12, "R8"); step(1, 5, "R8"); step(1, 8, "R8");
    step(1, 3, "R8"); step(1, 5, "R8"); step(1, 15, "R8"); step(1, 8, "R8");
    check("R8", int'(occ_count), 3);

    // R7: idle cycles inside a run, with 8 offered while invalid
    step(1, 3, "R7"); step(0, 8, "R7"); step(0, 3, "R7");
    step(1, 5, "R7"); step(0, 8, "R7"); step(1, 8, "R7");
    check("R7", int'(occ_count), 4);

    // R6: wrap from 4 to 0
    seq3(3, 5, 8, "R6");
    check("R6", int'(occ_count), 0);

    // R2: the new value appears only after the edge taking the final 8
    step(1, 3, "R2"); step(1, 5, "R2");
    in_valid = 1'b1; in_digit = 4'd8;
    #1 check("R2", int'(occ_count), 0);
    @(posedge clk); m_cnt = 1; m_trk = 0;
    @(negedge clk); check("R2", int'(occ_count), 1);

    // R1: reset mid-run clears the count and the tracker
    step(1, 3, "R1"); step(1, 5, "R1");
    do_reset();
    step(1, 8, "R1");
    check("R1", int'(occ_count), 0);

    // Random stream, biased toward the run symbols
    for (int i = 0; i < 3000; i++) begin
      int r;
      int d;
      bit v;
      r = int'($urandom_range(0, 9));
      case (r)
        0, 1, 2: d = 3;
        3, 4:    d = 5;
        5, 6:    d = 8;
        default: d = int'($urandom_range(0, 15));
      endcase
      v = ($urandom_range(0, 4) != 0);
      step(v, d, "R3");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule